// File: doc/BRIEF.md
# Pixel Clock Flywheel

This block regenerates a steady pixel timing reference from a camera pixel clock that reaches the logic over a rotating contact and can break up or vanish for a short time. It is clocked only by a free-running fast system clock, at least 50 MHz. It never uses the camera clock as a clock. Both the camera clock and the 10-bit pixel bus are resynchronised into the fast domain. The camera clock is then filtered so that short pulses cannot count as edges. A fractional phase accumulator tracks the nominal pixel period, so that the average strobe rate matches the pixel rate even though one period is not a whole number of fast cycles.

Clean rising edges that land close to the predicted edge pull the accumulator back into line. Edges far from the prediction are ignored. When the camera clock breaks up, the accumulator keeps running on its own and goes on producing one strobe per nominal period. A status pair reports whether the block is following edges or coasting. Downstream logic takes each one-cycle strobe, together with the word captured in the middle of the pixel period, as a pixel.

Top module: `pixel_flywheel`

## Requirements
- R1: A synchronous active-high reset clears the phase, the miss counter, the strobe and the captured word. It also sets both `locked` and `holdover` to 0, which is the acquiring state.
- R2: After the two synchroniser flops, a change in the camera clock level is taken only once it has held for `MIN_PULSE` consecutive fast cycles. Shorter pulses or dips cause no re-alignment, and so leave the strobe spacing unchanged.
- R3: While acquiring, the first filtered rising edge is accepted. It sets the phase to 0 and sets `locked` to 1.
- R4: The phase grows by `PHASE_INC` every cycle, modulo 2^`PHASE_W`. A strobe is asserted for exactly one cycle in the cycle after the phase crosses 2^(`PHASE_W`-1). With no accepted edge, consecutive strobes are therefore floor or ceil of 2^`PHASE_W`/`PHASE_INC` cycles apart.
- R5: `pix_data` takes the synchronised pixel bus value on the strobe cycle and holds it until the next strobe.
- R6: While locked, a filtered rising edge is accepted only if the phase is at least 2^`PHASE_W`-`WIN` or below `WIN`. Other edges are ignored.
- R7: An accepted edge sets the phase to 0. No strobe is produced on that step. The next strobe appears the fixed number of cycles later that is needed to reach the half-period mark, which is 5 cycles with the default parameters.
- R8: Each phase wrap without an accepted edge increments a miss count that saturates at `HOLD_PERIODS`. A wrap that occurs while the count is saturated moves a locked tracker to holdover. Strobes continue at the nominal rate in holdover.
- R9: In holdover, any filtered rising edge is accepted and returns the block to locked.
- R10: No strobe is produced while acquiring.
- R11: `locked` and `holdover` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_raw | input | 1 | Camera pixel clock after the rotating contact, asynchronous |
| pdata_raw | input | DATA_W | Camera pixel bus, asynchronous |
| pix_stb | output | 1 | One-cycle strobe per nominal pixel period |
| pix_data | output | DATA_W | Pixel word captured at mid-period |
| locked | output | 1 | Tracker is following accepted edges |
| holdover | output | 1 | Tracker is coasting after too many missed periods |

## Verification
On every cycle the assertions check the following: the two status outputs are exclusive; a strobe is never longer than one cycle and never appears while acquiring; the captured word changes only on a strobe; holdover is entered only from locked; the gap between strobes stays bounded. The bench scenarios show the rest: rejection of single-cycle glitches, the 5-cycle latency from acquisition to the first strobe, the strobe count and spacing across a long dropout, and the refusal of edges outside the window followed by the later re-lock. A behavioural model run beside the design compares the strobe, the word and both status bits on every cycle.

// File: rtl/flywheel_pkg.sv
package flywheel_pkg;

    typedef enum logic [1:0] {
        TRK_ACQUIRE = 2'd0,
        TRK_LOCKED  = 2'd1,
        TRK_COAST   = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic accept;
        logic wrap;
        logic mid;
    } trk_evt_t;

    // Phase lies near the predicted edge (the wrap point).
    function automatic logic near_wrap(input logic [31:0] ph,
                                       input logic [31:0] span,
                                       input logic [31:0] win);
        return (ph >= span - win) || (ph < win);
    endfunction

    // Phase steps across a mark on this increment.
    function automatic logic crosses(input logic [31:0] ph,
                                     input logic [31:0] inc,
                                     input logic [31:0] mark);
        return (ph < mark) && (ph + inc >= mark);
    endfunction

endpackage

// File: rtl/fw_sync.sv
module fw_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            dout <= '0;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/fw_deglitch.sv
module fw_deglitch #(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int CW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;

    logic          lvl;
    logic          lvl_d;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl   <= 1'b0;
            lvl_d <= 1'b0;
            run   <= '0;
        end else begin
            lvl_d <= lvl;
            if (din != lvl) begin
                if (run == CW'(MIN_PULSE - 1)) begin
                    lvl <= din;
                    run <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end else begin
                run <= '0;
            end
        end
    end

    assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/fw_tracker.sv
module fw_tracker
    import flywheel_pkg::*;
#(
    parameter int PHASE_W   = 16,
    parameter int PHASE_INC = 6894,
    parameter int WIN       = 16384,
    parameter int HOLD      = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rise_in,
    output trk_state_e state,
    output logic       mid_evt
);
    localparam logic [31:0] SPAN  = 32'(1) << PHASE_W;
    localparam logic [31:0] HALF  = SPAN >> 1;
    localparam logic [31:0] INC32 = 32'(PHASE_INC);
    localparam logic [31:0] WIN32 = 32'(WIN);
    localparam int          MW    = $clog2(HOLD + 1);

    logic [PHASE_W-1:0] phase;
    logic [MW-1:0]      miss;
    logic [31:0]        ph32;
    trk_evt_t           ev;

    assign ph32 = 32'(phase);

    always_comb begin
        ev.accept = rise_in && ((state != TRK_LOCKED) || near_wrap(ph32, SPAN, WIN32));
        ev.wrap   = (ph32 + INC32) >= SPAN;
        ev.mid    = crosses(ph32, INC32, HALF);
    end

    assign mid_evt = ev.mid && !ev.accept && (state != TRK_ACQUIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            miss  <= '0;
            state <= TRK_ACQUIRE;
        end else if (ev.accept) begin
            phase <= '0;
            miss  <= '0;
            state <= TRK_LOCKED;
        end else begin
            phase <= phase + PHASE_W'(PHASE_INC);
            if (ev.wrap) begin
                if (miss == MW'(HOLD)) begin
                    if (state == TRK_LOCKED) state <= TRK_COAST;
                end else begin
                    miss <= miss + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pixel_flywheel.sv
module pixel_flywheel
    import flywheel_pkg::*;
#(
    parameter int DATA_W       = 10,
    parameter int PHASE_W      = 16,
    parameter int PHASE_INC    = 6894,
    parameter int WIN          = 16384,
    parameter int MIN_PULSE    = 2,
    parameter int HOLD_PERIODS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pclk_raw,
    input  logic [DATA_W-1:0] pdata_raw,
    output logic              pix_stb,
    output logic [DATA_W-1:0] pix_data,
    output logic              locked,
    output logic              holdover
);
    localparam int SW = DATA_W + 1;

    logic [SW-1:0] synced;
    logic          rise;
    logic          mid;
    trk_state_e    st;

    fw_sync #(.W(SW)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({pclk_raw, pdata_raw}),
        .dout (synced)
    );

    fw_deglitch #(.MIN_PULSE(MIN_PULSE)) u_deglitch (
        .clk  (clk),
        .rst  (rst),
        .din  (synced[SW-1]),
        .rise (rise)
    );

    fw_tracker #(
        .PHASE_W   (PHASE_W),
        .PHASE_INC (PHASE_INC),
        .WIN       (WIN),
        .HOLD      (HOLD_PERIODS)
    ) u_tracker (
        .clk     (clk),
        .rst     (rst),
        .rise_in (rise),
        .state   (st),
        .mid_evt (mid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_stb  <= 1'b0;
            pix_data <= '0;
        end else begin
            pix_stb <= mid;
            if (mid) pix_data <= synced[DATA_W-1:0];
        end
    end

    assign locked   = (st == TRK_LOCKED);
    assign holdover = (st == TRK_COAST);
endmodule

// File: rtl/pixel_flywheel_chk.sv
module pixel_flywheel_chk #(
    parameter int PHASE_W   = 16,
    parameter int PHASE_INC = 6894,
    parameter int DATA_W    = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              pix_stb,
    input logic [DATA_W-1:0] pix_data,
    input logic              locked,
    input logic              holdover
);
    localparam int MAX_GAP = ((1 << PHASE_W) + (1 << (PHASE_W - 1))) / PHASE_INC + 3;

    logic [15:0] gap;

    always_ff @(posedge clk) begin
        if (rst || pix_stb || !(locked || holdover)) gap <= '0;
        else if (gap != '1) gap <= gap + 1'b1;
    end

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!locked && !holdover && !pix_stb && pix_data == '0));

    assert_single_cycle_stb_R4: assert property (@(posedge clk) disable iff (rst)
        pix_stb |=> !pix_stb);

    assert_gap_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        gap <= 16'(MAX_GAP));

    assert_data_held_R5: assert property (@(posedge clk) disable iff (rst)
        !pix_stb |-> $stable(pix_data));

    assert_coast_from_lock_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(holdover) |-> $past(locked));

    assert_no_stb_acquiring_R10: assert property (@(posedge clk) disable iff (rst)
        pix_stb |-> (locked || holdover));

    assert_status_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(locked && holdover));
endmodule

bind pixel_flywheel pixel_flywheel_chk #(
    .PHASE_W   (PHASE_W),
    .PHASE_INC (PHASE_INC),
    .DATA_W    (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pix_stb  (pix_stb),
    .pix_data (pix_data),
    .locked   (locked),
    .holdover (holdover)
);

// File: tb/pixel_flywheel_test.sv
module pixel_flywheel_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW      = 10;
    localparam int P_INC   = 6894;
    localparam int SPAN    = 65536;
    localparam int HALF    = 32768;
    localparam int WIN     = 16384;
    localparam int MIN_P   = 2;
    localparam int HOLD    = 16;
    localparam int SRC_INC = 6899;
    localparam int WDOG    = 50000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pclk_raw = 1'b0;
    logic [DW-1:0] pdata_raw = '0;
    logic          pix_stb;
    logic [DW-1:0] pix_data;
    logic          locked;
    logic          holdover;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pixel_flywheel uut (
        .clk(clk), .rst(rst), .pclk_raw(pclk_raw), .pdata_raw(pdata_raw),
        .pix_stb(pix_stb), .pix_data(pix_data), .locked(locked), .holdover(holdover)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference, advanced on every rising clock edge.
    int m_s1, m_s2, m_d1, m_d2, m_lvl, m_lvld, m_run;
    int m_ph, m_st, m_miss, m_stb, m_data;
    always @(posedge clk) begin : model
        int rise_m, inwin, acc_m, wrap_m, mid_m;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_d1 = 0; m_d2 = 0; m_lvl = 0; m_lvld = 0; m_run = 0;
            m_ph = 0; m_st = 0; m_miss = 0; m_stb = 0; m_data = 0;
        end else begin
            rise_m = (m_lvl == 1 && m_lvld == 0) ? 1 : 0;
            inwin  = (m_ph >= SPAN - WIN || m_ph < WIN) ? 1 : 0;
            acc_m  = (rise_m == 1 && (m_st != 1 || inwin == 1)) ? 1 : 0;
            wrap_m = (m_ph + P_INC >= SPAN) ? 1 : 0;
            mid_m  = (m_ph < HALF && m_ph + P_INC >= HALF) ? 1 : 0;
            m_stb  = (mid_m == 1 && acc_m == 0 && m_st != 0) ? 1 : 0;
            if (m_stb == 1) m_data = m_d2;
            if (acc_m == 1) begin
                m_ph = 0; m_st = 1; m_miss = 0;
            end else begin
                m_ph = (m_ph + P_INC) % SPAN;
                if (wrap_m == 1) begin
                    if (m_miss == HOLD) begin
                        if (m_st == 1) m_st = 2;
                    end else m_miss++;
                end
            end
            m_lvld = m_lvl;
            if (m_s2 != m_lvl) begin
                if (m_run == MIN_P - 1) begin m_lvl = m_s2; m_run = 0; end
                else m_run++;
            end else m_run = 0;
            m_s2 = m_s1; m_s1 = int'(pclk_raw);
            m_d2 = m_d1; m_d1 = int'(pdata_raw);
        end
    end

    // Source camera clock and scenario control.
    int src_acc = 0;
    int pix_idx = 0;
    int mode = 0;          // 0 clean, 2 glitchy, 3 dropout
    int cyc_n = 0;
    int last_stb = -1;
    int prev_locked = 0;
    int lock_cyc = -1;
    int seg_min, seg_max, seg_cnt, seg_hold;

    always @(posedge clk) begin
        if (cyc_n > WDOG) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_n, WDOG);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic drive();
        int lv;
        src_acc = src_acc + SRC_INC;
        if (src_acc >= SPAN) begin src_acc -= SPAN; pix_idx++; end
        lv = (src_acc < HALF) ? 1 : 0;
        if (mode == 2) begin
            if (src_acc >= 19661 && src_acc < 26214) lv = 0;  // 1-cycle dip
            if (src_acc >= 39322 && src_acc < 45875) lv = 1;  // 1-cycle spike
        end
        if (mode == 3) lv = 0;
        pclk_raw  = lv[0];
        pdata_raw = DW'((pix_idx * 37 + 5) % 1024);
    endtask

    task automatic step(input bit measure);
        @(negedge clk);
        cyc_n++;
        if (!rst) begin
            chk("R4 strobe vs model", int'(pix_stb), m_stb);
            chk("R5 data vs model", int'(pix_data), m_data);
            chk("R3 locked vs model", int'(locked), m_st == 1 ? 1 : 0);
            chk("R8 holdover vs model", int'(holdover), m_st == 2 ? 1 : 0);
        end
        if (locked && prev_locked == 0) lock_cyc = cyc_n;
        if (pix_stb) begin
            if (lock_cyc >= 0) begin
                chk("R7 first strobe after accept", cyc_n - lock_cyc, 5);
                lock_cyc = -1;
            end
            if (measure && last_stb >= 0) begin
                if (cyc_n - last_stb < seg_min) seg_min = cyc_n - last_stb;
                if (cyc_n - last_stb > seg_max) seg_max = cyc_n - last_stb;
            end
            if (measure) seg_cnt++;
            last_stb = cyc_n;
        end
        if (measure && holdover) seg_hold = 1;
        prev_locked = int'(locked);
        drive();
    endtask

    task automatic run_seg(input int n, input int skip);
        seg_min = 1000; seg_max = 0; seg_cnt = 0; seg_hold = 0;
        for (int i = 0; i < n; i++) step(i >= skip);
    endtask

    initial begin
        mode = 3;
        rst = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b0);
        rst = 1'b0;
        step(1'b0);
        chk("R1 reset stb", int'(pix_stb), 0);
        chk("R1 reset data", int'(pix_data), 0);
        chk("R1 reset locked", int'(locked), 0);
        chk("R1 reset holdover", int'(holdover), 0);

        // Acquiring with no clock: no strobes.
        run_seg(60, 0);
        chk("R10 no strobe while acquiring", seg_cnt, 0);
        chk("R3 still acquiring", int'(locked), 0);

        // Clean clock: acquire and track.
        mode = 0;
        run_seg(600, 100);
        chk("R3 locked on clean clock", int'(locked), 1);
        chk("R4 clean spacing max", int'(seg_max <= 10), 1);
        chk("R4 clean spacing min", int'(seg_min >= 8), 1);

        // Short glitches must not re-align.
        mode = 2;
        run_seg(600, 20);
        chk("R2 glitch spacing max", int'(seg_max <= 10), 1);
        chk("R2 still locked", int'(locked), 1);

        // Long dropout: flywheel.
        mode = 3;
        run_seg(1000, 200);
        chk("R8 strobe count in dropout", int'(seg_cnt >= 84 && seg_cnt <= 85), 1);
        chk("R4 dropout spacing min", seg_min, 9);
        chk("R4 dropout spacing max", seg_max, 10);
        chk("R8 holdover after dropout", int'(holdover), 1);

        // Clock returns.
        mode = 0;
        run_seg(300, 0);
        chk("R9 relocked", int'(locked), 1);

        // Half-period shift: edges land outside the window.
        src_acc = (src_acc + HALF) % SPAN;
        run_seg(140, 10);
        chk("R6 out-of-window edges ignored (min)", int'(seg_min >= 9), 1);
        chk("R6 out-of-window edges ignored (max)", int'(seg_max <= 10), 1);
        run_seg(300, 0);
        chk("R6 holdover reached", seg_hold, 1);
        chk("R9 relocked after shift", int'(locked), 1);

        // Reset mid-run.
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0);
        rst = 1'b0;
        step(1'b0);
        chk("R1 mid-run reset locked", int'(locked), 0);
        chk("R1 mid-run reset stb", int'(pix_stb), 0);
        chk("R1 mid-run reset data", int'(pix_data), 0);
        run_seg(200, 0);
        chk("R3 reacquired after reset", int'(locked), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule